// File: doc/BRIEF.md
# Absolute Position Encoder Serial Reader

This block is the master side of a synchronous serial link to an absolute position encoder. On a one-cycle request it drives the encoder clock line low and high in a burst of half-periods, one low pulse per frame bit, and captures the data line at each rising edge into a receive frame. After the last rising edge it holds the line high for a recovery window so the encoder's internal hold timer expires. Only then does it publish a new result.

Frame layout is set at run time. Software-visible configuration inputs give the frame length, the start position and length of the single-turn field, the start position and length of an optional multi-turn field, the position of the status bit and a parity mode. A direction input makes the reported position count the other way. Data is treated as plain binary. The configuration inputs must be held steady from the request until the valid pulse.

Frame position 0 is the first bit received. Within a field, the bit at the field's start position is the most significant. Half-period and recovery lengths are parameters in system clock cycles. With a 250 MHz system clock, the defaults of 62 and 2500 give about a 2 MHz link clock and a 10 µs recovery.

Top module: `ssi_position_reader`

## Requirements
- R1: After reset the clock line is high, the valid and parity error outputs are low, and both position outputs and the status output are zero.
- R2: A request issues exactly N low pulses on the clock line, where N is the frame length clamped to 1..MAX_FRAME (a length of 0 acts as 1). Each low and each inner high phase lasts HALF_DIV system cycles, and the line is high whenever no transfer is running.
- R3: The frame bit at position k is the data line level captured at the k-th rising clock edge of the burst, counted from 0. The data line passes through a synchronizer first.
- R4: The valid output is high for exactly one cycle, exactly MONO_CYCLES system cycles after the clock line's last rising edge, and it pulses once per accepted request.
- R5: A request that arrives while a transfer or its recovery window is running is ignored. The burst length and the number of valid pulses are unchanged.
- R6: The raw single-turn value is built from the frame bits at positions start..start+len-1, with the bit at the start position as the MSB. The length is clamped to ST_MAX. Positions beyond the frame, or beyond MAX_FRAME, read as 0.
- R7: The multi-turn field follows the same rule with its own start and length, clamped to MT_MAX. A length of 0 reports 0.
- R8: The status output is the frame bit at the configured status position, or 0 when that position lies outside the frame.
- R9: Parity mode encoding is 0 = none, 1 = even, 2 = odd, 3 = none. In even mode the error is set when the XOR of all frame bits is 1. In odd mode the error is set when that XOR is 0. Otherwise the error is 0.
- R10: With the direction input at 1, the combined value {multi, single} is negated modulo 2^(mtLen+stLen). The single-turn output is therefore (2^stLen − raw) mod 2^stLen, and the multi-turn output takes the borrow.
- R11: Position, status and error outputs change only in the cycle valid is high, and they hold their values between valid pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqStart | input | 1 | One-cycle request to read a frame |
| frameLen | input | POS_W | Frame length in bits |
| stStart | input | POS_W | Frame position of single-turn MSB |
| stLen | input | POS_W | Single-turn field length |
| mtStart | input | POS_W | Frame position of multi-turn MSB |
| mtLen | input | POS_W | Multi-turn field length, 0 = absent |
| statusPos | input | POS_W | Frame position of the status bit |
| parityMode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| reverseDir | input | 1 | 1 = report the negated position |
| sclkOut | output | 1 | Encoder clock line, idles high |
| dataIn | input | 1 | Encoder data line |
| stPos | output | ST_MAX | Single-turn position |
| mtPos | output | MT_MAX | Multi-turn position |
| statusOut | output | 1 | Status bit of the last frame |
| posValid | output | 1 | One-cycle pulse when results update |
| parityErr | output | 1 | Parity failure of the last frame |

## Verification
A bit counter that slips in the control shows up on the very next frame as the wrong number of low pulses on the clock line. It also shows as a field shifted by one position, which the next valid pulse exposes. A wrong half-period or recovery counter moves the clock edges, or the valid pulse, by a countable number of system cycles, so the bench measures these timings directly. Errors in field extraction, negation and parity reveal themselves in the published values at the valid pulse that ends the affected frame. The vectors include a zero single-turn field under reversal, out-of-frame positions and clamped lengths, so that faults in the boundary handling do not stay hidden.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

  typedef enum logic [1:0] {
    LINK_IDLE = 2'd0,
    LINK_LOW  = 2'd1,
    LINK_HIGH = 2'd2,
    LINK_REST = 2'd3
  } linkState_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_OFF  = 2'd3
  } parMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // new frame begins
    logic sample;   // capture the data line at this rising edge
    logic publish;  // recovery wait over, register results
  } dpStrobe_t;

endpackage

// File: rtl/ssi_link_ctrl.sv
module ssi_link_ctrl
  import ssi_pkg::*;
#(
  parameter int HALF_DIV    = 62,
  parameter int MONO_CYCLES = 2500,
  parameter int MAX_FRAME   = 32,
  parameter int POS_W       = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqStart,
  input  logic [POS_W-1:0] frameLen,
  output logic             sclkOut,
  output dpStrobe_t        strobe,
  output logic [POS_W-1:0] bitIdx,
  output logic             busy
);

  localparam int DIV_W  = $clog2(HALF_DIV + 1);
  localparam int MONO_W = $clog2(MONO_CYCLES + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST  = DIV_W'(HALF_DIV - 1);
  localparam logic [MONO_W-1:0] MONO_LAST = MONO_W'(MONO_CYCLES - 1);
  localparam logic [POS_W-1:0]  FRAME_CAP = POS_W'(MAX_FRAME);

  linkState_e        state;
  logic [DIV_W-1:0]  divCnt;
  logic [MONO_W-1:0] monoCnt;
  logic [POS_W-1:0]  bitCnt;
  logic [POS_W-1:0]  effLen;
  logic [POS_W-1:0]  lastIdx;
  logic              sclkReg;
  logic              divDone;
  logic              monoDone;

  always_comb begin
    if (frameLen == '0)           effLen = POS_W'(1);
    else if (frameLen > FRAME_CAP) effLen = FRAME_CAP;
    else                          effLen = frameLen;
    lastIdx  = effLen - POS_W'(1);
    divDone  = (divCnt == DIV_LAST);
    monoDone = (monoCnt == MONO_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= LINK_IDLE;
      sclkReg <= 1'b1;
      divCnt  <= '0;
      monoCnt <= '0;
      bitCnt  <= '0;
    end else begin
      unique case (state)
        LINK_IDLE: begin
          if (reqStart) begin
            state   <= LINK_LOW;
            sclkReg <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= '0;
          end
        end
        LINK_LOW: begin
          if (divDone) begin
            sclkReg <= 1'b1;
            divCnt  <= '0;
            if (bitCnt == lastIdx) begin
              state   <= LINK_REST;
              monoCnt <= '0;
            end else begin
              state <= LINK_HIGH;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        LINK_HIGH: begin
          if (divDone) begin
            sclkReg <= 1'b0;
            divCnt  <= '0;
            bitCnt  <= bitCnt + POS_W'(1);
            state   <= LINK_LOW;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        LINK_REST: begin
          if (monoDone) state <= LINK_IDLE;
          else          monoCnt <= monoCnt + MONO_W'(1);
        end
        default: state <= LINK_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.clear   = (state == LINK_IDLE) && reqStart;
    strobe.sample  = (state == LINK_LOW) && divDone;
    strobe.publish = (state == LINK_REST) && monoDone;
  end

  assign bitIdx  = bitCnt;
  assign sclkOut = sclkReg;
  assign busy    = (state != LINK_IDLE);

endmodule

// File: rtl/ssi_frame_dp.sv
module ssi_frame_dp
  import ssi_pkg::*;
#(
  parameter int MAX_FRAME   = 32,
  parameter int ST_MAX      = 32,
  parameter int MT_MAX      = 16,
  parameter int POS_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [POS_W-1:0]  bitIdx,
  input  logic              dataIn,
  input  logic [POS_W-1:0]  stStart,
  input  logic [POS_W-1:0]  stLen,
  input  logic [POS_W-1:0]  mtStart,
  input  logic [POS_W-1:0]  mtLen,
  input  logic [POS_W-1:0]  statusPos,
  input  logic [1:0]        parityMode,
  input  logic              reverseDir,
  output logic [ST_MAX-1:0] stPos,
  output logic [MT_MAX-1:0] mtPos,
  output logic              statusOut,
  output logic              posValid,
  output logic              parityErr
);

  logic [SYNC_STAGES-1:0] syncChain;
  logic                   dataSync;
  logic [MAX_FRAME-1:0]   rxBits;

  // input synchronizer, depth chosen by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= dataIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain <= '1;
        else       syncChain <= {syncChain[SYNC_STAGES-2:0], dataIn};
      end
    end
  endgenerate
  assign dataSync = syncChain[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxBits <= '0;
    end else if (strobe.clear) begin
      rxBits <= '0;
    end else if (strobe.sample) begin
      for (int b = 0; b < MAX_FRAME; b++) begin
        if (bitIdx == POS_W'(b)) rxBits[b] <= dataSync;
      end
    end
  end

  // collect count bits starting at start, first bit ends up as MSB
  function automatic logic [MAX_FRAME-1:0] pickField(
    input logic [MAX_FRAME-1:0] bits,
    input logic [POS_W-1:0]     start,
    input int                   count
  );
    logic [MAX_FRAME-1:0] shifted;
    logic [MAX_FRAME-1:0] acc;
    shifted = bits >> start;
    acc     = '0;
    for (int i = 0; i < MAX_FRAME; i++) begin
      if (i < count) acc = {acc[MAX_FRAME-2:0], shifted[i]};
    end
    return acc;
  endfunction

  int                   stLenEff;
  int                   mtLenEff;
  logic [ST_MAX-1:0]    stMask;
  logic [MT_MAX-1:0]    mtMask;
  logic [ST_MAX-1:0]    stRaw;
  logic [MT_MAX-1:0]    mtRaw;
  logic [ST_MAX-1:0]    stNext;
  logic [MT_MAX-1:0]    mtNext;
  logic [MAX_FRAME-1:0] statShift;
  logic                 statBit;
  logic                 frameXor;
  logic                 errNext;

  always_comb begin
    stLenEff = (int'(stLen) > ST_MAX) ? ST_MAX : int'(stLen);
    mtLenEff = (int'(mtLen) > MT_MAX) ? MT_MAX : int'(mtLen);
    for (int i = 0; i < ST_MAX; i++) stMask[i] = (i < stLenEff);
    for (int i = 0; i < MT_MAX; i++) mtMask[i] = (i < mtLenEff);
    stRaw = ST_MAX'(pickField(rxBits, stStart, stLenEff)) & stMask;
    mtRaw = MT_MAX'(pickField(rxBits, mtStart, mtLenEff)) & mtMask;
    if (reverseDir) begin
      // negate {mt, st}: borrow into mt unless st is zero
      stNext = (~stRaw + ST_MAX'(1)) & stMask;
      mtNext = ((stRaw == '0) ? (~mtRaw + MT_MAX'(1)) : ~mtRaw) & mtMask;
    end else begin
      stNext = stRaw;
      mtNext = mtRaw;
    end
    statShift = rxBits >> statusPos;
    statBit   = statShift[0];
    frameXor  = ^rxBits;
    unique case (parMode_e'(parityMode))
      PAR_EVEN: errNext = frameXor;
      PAR_ODD:  errNext = ~frameXor;
      default:  errNext = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stPos     <= '0;
      mtPos     <= '0;
      statusOut <= 1'b0;
      parityErr <= 1'b0;
      posValid  <= 1'b0;
    end else begin
      posValid <= strobe.publish;
      if (strobe.publish) begin
        stPos     <= stNext;
        mtPos     <= mtNext;
        statusOut <= statBit;
        parityErr <= errNext;
      end
    end
  end

endmodule

// File: rtl/ssi_position_reader.sv
module ssi_position_reader
  import ssi_pkg::*;
#(
  parameter int MAX_FRAME   = 32,
  parameter int ST_MAX      = 32,
  parameter int MT_MAX      = 16,
  parameter int HALF_DIV    = 62,
  parameter int MONO_CYCLES = 2500,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W      = $clog2(MAX_FRAME) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqStart,
  input  logic [POS_W-1:0]  frameLen,
  input  logic [POS_W-1:0]  stStart,
  input  logic [POS_W-1:0]  stLen,
  input  logic [POS_W-1:0]  mtStart,
  input  logic [POS_W-1:0]  mtLen,
  input  logic [POS_W-1:0]  statusPos,
  input  logic [1:0]        parityMode,
  input  logic              reverseDir,
  output logic              sclkOut,
  input  logic              dataIn,
  output logic [ST_MAX-1:0] stPos,
  output logic [MT_MAX-1:0] mtPos,
  output logic              statusOut,
  output logic              posValid,
  output logic              parityErr
);

  dpStrobe_t        strobe;
  logic [POS_W-1:0] bitIdx;
  logic             ctrlBusy;

  ssi_link_ctrl #(
    .HALF_DIV(HALF_DIV), .MONO_CYCLES(MONO_CYCLES),
    .MAX_FRAME(MAX_FRAME), .POS_W(POS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .frameLen(frameLen),
    .sclkOut(sclkOut), .strobe(strobe), .bitIdx(bitIdx), .busy(ctrlBusy)
  );

  ssi_frame_dp #(
    .MAX_FRAME(MAX_FRAME), .ST_MAX(ST_MAX), .MT_MAX(MT_MAX),
    .POS_W(POS_W), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitIdx(bitIdx), .dataIn(dataIn),
    .stStart(stStart), .stLen(stLen), .mtStart(mtStart), .mtLen(mtLen),
    .statusPos(statusPos), .parityMode(parityMode), .reverseDir(reverseDir),
    .stPos(stPos), .mtPos(mtPos), .statusOut(statusOut),
    .posValid(posValid), .parityErr(parityErr)
  );

endmodule

// File: rtl/ssi_position_reader_chk.sv
module ssi_position_reader_chk #(
  parameter int MAX_FRAME   = 32,
  parameter int ST_MAX      = 32,
  parameter int MT_MAX      = 16,
  parameter int HALF_DIV    = 62,
  parameter int MONO_CYCLES = 2500,
  parameter int POS_W       = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic [POS_W-1:0]  frameLen,
  input logic              sclkOut,
  input logic              busy,
  input logic [ST_MAX-1:0] stPos,
  input logic [MT_MAX-1:0] mtPos,
  input logic              statusOut,
  input logic              posValid,
  input logic              parityErr
);

  logic        prevSclk;
  int unsigned lowRun;
  int unsigned sinceRise;
  int unsigned fallCnt;
  int unsigned effLen;

  always_comb begin
    if (frameLen == '0)               effLen = 1;
    else if (int'(frameLen) > MAX_FRAME) effLen = MAX_FRAME;
    else                              effLen = int'(frameLen);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSclk  <= 1'b1;
      lowRun    <= 0;
      sinceRise <= 0;
      fallCnt   <= 0;
    end else begin
      prevSclk <= sclkOut;
      lowRun   <= sclkOut ? 0 : lowRun + 1;
      if (sclkOut && !prevSclk) sinceRise <= 0;
      else if (sinceRise != 32'hFFFF_FFFF) sinceRise <= sinceRise + 1;
      if (posValid) fallCnt <= 0;
      else if (prevSclk && !sclkOut) fallCnt <= fallCnt + 1;
    end
  end

  // R2: line is high whenever no transfer runs
  a_r2_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> sclkOut);

  // R2: each low phase lasts HALF_DIV cycles
  a_r2_low_width: assert property (@(posedge clk) disable iff (!rstN)
    (sclkOut && !prevSclk) |-> (lowRun == HALF_DIV));

  // R2: one low pulse per frame bit
  a_r2_pulse_count: assert property (@(posedge clk) disable iff (!rstN)
    posValid |-> (fallCnt == effLen));

  // R4: valid is a single-cycle pulse
  a_r4_valid_single: assert property (@(posedge clk) disable iff (!rstN)
    posValid |=> !posValid);

  // R4: recovery window respected before publishing
  a_r4_mono_wait: assert property (@(posedge clk) disable iff (!rstN)
    posValid |-> (sinceRise >= MONO_CYCLES - 1));

  // R11: results hold between valid pulses
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !posValid |-> ($stable(stPos) && $stable(mtPos) &&
                   $stable(statusOut) && $stable(parityErr)));

endmodule

bind ssi_position_reader ssi_position_reader_chk #(
  .MAX_FRAME(MAX_FRAME), .ST_MAX(ST_MAX), .MT_MAX(MT_MAX),
  .HALF_DIV(HALF_DIV), .MONO_CYCLES(MONO_CYCLES), .POS_W(POS_W)
) u_chk (
  .clk(clk), .rstN(rstN), .frameLen(frameLen), .sclkOut(sclkOut),
  .busy(ctrlBusy), .stPos(stPos), .mtPos(mtPos), .statusOut(statusOut),
  .posValid(posValid), .parityErr(parityErr)
);

// File: tb/test_ssi_position_reader.sv
`timescale 1ns/1ps
module test_ssi_position_reader;

  localparam int HALF = 4;
  localparam int MONO = 40;
  localparam int PW   = 6;

  typedef struct packed {
    logic [31:0]   bits;   // bits[k] is frame position k
    logic [PW-1:0] len;
    logic [PW-1:0] stS;
    logic [PW-1:0] stL;
    logic [PW-1:0] mtS;
    logic [PW-1:0] mtL;
    logic [PW-1:0] stat;
    logic [1:0]    par;
    logic          rev;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h05A3_C96B, 6'd27, 6'd0,  6'd24, 6'd0,  6'd0,  6'd24, 2'd0, 1'b0},
    '{32'h05A3_C96B, 6'd27, 6'd0,  6'd24, 6'd0,  6'd0,  6'd24, 2'd0, 1'b1},
    '{32'h9E37_79B9, 6'd26, 6'd12, 6'd13, 6'd0,  6'd12, 6'd25, 2'd1, 1'b0},
    '{32'h9E37_79B9, 6'd26, 6'd12, 6'd13, 6'd0,  6'd12, 6'd25, 2'd2, 1'b1},
    '{32'h0000_00A5, 6'd20, 6'd8,  6'd10, 6'd0,  6'd8,  6'd19, 2'd0, 1'b1},
    '{32'hDEAD_BEEF, 6'd32, 6'd0,  6'd32, 6'd0,  6'd0,  6'd31, 2'd1, 1'b1},
    '{32'h1234_5678, 6'd30, 6'd2,  6'd40, 6'd0,  6'd16, 6'd0,  2'd3, 1'b0},
    '{32'hFFFF_FFFF, 6'd8,  6'd4,  6'd8,  6'd60, 6'd4,  6'd7,  2'd2, 1'b0},
    '{32'h0F0F_0F0F, 6'd0,  6'd0,  6'd4,  6'd0,  6'd0,  6'd0,  2'd1, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqStart = 1'b0;
  logic [PW-1:0] frameLen = '0, stStart = '0, stLen = '0;
  logic [PW-1:0] mtStart = '0, mtLen = '0, statusPos = '0;
  logic [1:0] parityMode = '0;
  logic reverseDir = 1'b0;
  logic sclkOut;
  logic dataIn = 1'b1;
  logic [31:0] stPos;
  logic [15:0] mtPos;
  logic statusOut, posValid, parityErr;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ssi_position_reader #(.HALF_DIV(HALF), .MONO_CYCLES(MONO)) i_ssi_position_reader (
    .clk(clk), .rstN(rstN), .reqStart(reqStart), .frameLen(frameLen),
    .stStart(stStart), .stLen(stLen), .mtStart(mtStart), .mtLen(mtLen),
    .statusPos(statusPos), .parityMode(parityMode), .reverseDir(reverseDir),
    .sclkOut(sclkOut), .dataIn(dataIn), .stPos(stPos), .mtPos(mtPos),
    .statusOut(statusOut), .posValid(posValid), .parityErr(parityErr)
  );

  // encoder model: next bit appears on each falling clock edge
  logic [31:0] encFrame = '0;
  int encPtr = 0;
  always @(negedge sclkOut) begin
    dataIn = encFrame[encPtr % 32];
    encPtr = encPtr + 1;
  end

  // port monitor, sampled away from the active edge
  logic prevS = 1'b1;
  int fallCnt = 0, validCnt = 0, lowRun = 0, lastLow = 0, sinceRise = 0, gap = 0;
  always @(negedge clk) begin
    if (prevS && !sclkOut) fallCnt = fallCnt + 1;
    if (!sclkOut) lowRun = lowRun + 1;
    else if (!prevS) begin lastLow = lowRun; lowRun = 0; end
    if (!prevS && sclkOut) sinceRise = 0;
    else sinceRise = sinceRise + 1;
    if (posValid) begin validCnt = validCnt + 1; gap = sinceRise; end
    prevS = sclkOut;
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic void refModel(input vec_t v, output logic [31:0] st,
                                   output logic [15:0] mt, output logic stat,
                                   output logic err);
    int eff, sl, ml, pos;
    logic [31:0] seen;
    logic [63:0] stRaw, mtRaw, comb;
    logic x;
    eff = (v.len == 0) ? 1 : ((int'(v.len) > 32) ? 32 : int'(v.len));
    seen = (eff == 32) ? v.bits : (v.bits & ((32'd1 << eff) - 1));
    sl = (int'(v.stL) > 32) ? 32 : int'(v.stL);
    ml = (int'(v.mtL) > 16) ? 16 : int'(v.mtL);
    stRaw = 0;
    for (int i = 0; i < sl; i++) begin
      pos = int'(v.stS) + i;
      stRaw = (stRaw << 1) | ((pos < 32) ? 64'(seen[pos]) : 64'd0);
    end
    mtRaw = 0;
    for (int i = 0; i < ml; i++) begin
      pos = int'(v.mtS) + i;
      mtRaw = (mtRaw << 1) | ((pos < 32) ? 64'(seen[pos]) : 64'd0);
    end
    comb = (mtRaw << sl) | stRaw;
    if (v.rev) comb = (64'd0 - comb) & ((64'd1 << (sl + ml)) - 1);
    st = 32'(comb & ((64'd1 << sl) - 1));
    mt = 16'(comb >> sl);
    stat = (int'(v.stat) < 32) ? seen[v.stat] : 1'b0;
    x = ^seen;
    err = (v.par == 2'd1) ? x : ((v.par == 2'd2) ? ~x : 1'b0);
  endfunction

  task automatic runFrame(input vec_t v, input bit extraReq);
    @(negedge clk);
    frameLen = v.len; stStart = v.stS; stLen = v.stL; mtStart = v.mtS;
    mtLen = v.mtL; statusPos = v.stat; parityMode = v.par; reverseDir = v.rev;
    encFrame = v.bits; encPtr = 0;
    fallCnt = 0; validCnt = 0;
    reqStart = 1'b1;
    @(negedge clk);
    reqStart = 1'b0;
    if (extraReq) begin
      repeat (HALF * 3) @(negedge clk);
      reqStart = 1'b1;   // arrives mid-burst
      @(negedge clk);
      reqStart = 1'b0;
    end
    for (int t = 0; t < 2000; t++) begin
      @(posedge clk);
      if (validCnt != 0) break;
    end
    repeat (3 * HALF + MONO) @(negedge clk);
  endtask

  initial begin
    logic [31:0] eSt; logic [15:0] eMt; logic eStat, eErr; int eff;
    logic [31:0] holdSt;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sclk idle", 64'(sclkOut), 64'd1);
    chk("R1 valid", 64'(posValid), 64'd0);
    chk("R1 stPos", 64'(stPos), 64'd0);
    chk("R1 mtPos+status+err", {mtPos, statusOut, parityErr}, 64'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    for (int n = 0; n < NV; n++) begin
      runFrame(VECS[n], 1'b0);
      refModel(VECS[n], eSt, eMt, eStat, eErr);
      eff = (VECS[n].len == 0) ? 1 : int'(VECS[n].len);
      chk($sformatf("R2 pulses v%0d", n), 64'(fallCnt), 64'(eff));
      chk($sformatf("R2 low width v%0d", n), 64'(lastLow), 64'(HALF));
      chk($sformatf("R4 one valid v%0d", n), 64'(validCnt), 64'd1);
      chk($sformatf("R4 mono gap v%0d", n), 64'(gap), 64'(MONO));
      chk($sformatf("R3 R6 R10 single v%0d", n), 64'(stPos), 64'(eSt));
      chk($sformatf("R7 R10 multi v%0d", n), 64'(mtPos), 64'(eMt));
      chk($sformatf("R8 status v%0d", n), 64'(statusOut), 64'(eStat));
      chk($sformatf("R9 parity v%0d", n), 64'(parityErr), 64'(eErr));
    end

    // R5: second request mid-frame is ignored
    runFrame(VECS[0], 1'b1);
    refModel(VECS[0], eSt, eMt, eStat, eErr);
    chk("R5 pulses with extra request", 64'(fallCnt), 64'd27);
    chk("R5 single valid with extra request", 64'(validCnt), 64'd1);
    chk("R5 value unaffected", 64'(stPos), 64'(eSt));

    // R11: outputs hold while config and line change without a request
    holdSt = stPos;
    @(negedge clk);
    reverseDir = ~reverseDir; stStart = 6'd3; parityMode = 2'd2;
    dataIn = ~dataIn;
    repeat (60) @(negedge clk);
    chk("R11 stPos held", 64'(stPos), 64'(holdSt));
    chk("R11 no valid without request", 64'(validCnt), 64'd1);
    chk("R2 R11 line idle high", 64'(sclkOut), 64'd1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule